// File: doc/BRIEF.md
# I2C SCL Split-Divider Clock Generator

This block produces the SCL waveform that an I2C master drives onto the bus. The low phase and the high phase are timed separately. Each one is set by its own 16-bit field in a 32-bit divider word. One field unit is a fixed run of eight input clocks, and the hardware adds one unit of its own, so a field value of `d` gives a phase of `8*(d+1)` clocks. A field value of zero is legal and gives the shortest phase.

Besides the SCL level, the block gives a byte sequencer its timing points, each as a one-cycle pulse:
- a launch strobe at the midpoint of every low phase, where SDA may change;
- a sample strobe at the midpoint of every high phase, where SDA is read;
- a low-done pulse on the last cycle of each low phase;
- a high-done pulse on the last cycle of each high phase.

A sequencer uses the done pulses to frame START and STOP conditions around the clock edges.

Internally, a three-state machine drives the block:
- `ST_OFF`: SCL is released high.
- `ST_LOW`: SCL is driven low.
- `ST_HIGH`: SCL is released high.

Its transitions are:
- OFF→LOW when `enable` is sampled high;
- LOW→HIGH when the low count runs out;
- HIGH→LOW when the high count runs out;
- any state→OFF when `enable` is sampled low.

A divide-by-eight prescaler feeds one shared phase counter. That counter reloads on every SCL transition. The divider word is captured only when the machine enters `ST_LOW`.

Top module: `scl_split_clkgen`

## Requirements
- R1: The low-phase divider is `div_word[15:0]` and the high-phase divider is `div_word[31:16]`.
- R2: Each low phase holds `scl` at 0 for exactly 8*(low+1) consecutive clock cycles.
- R3: Each high phase inside a running burst holds `scl` at 1 for exactly 8*(high+1) cycles, after which `scl` falls again.
- R4: `launch_stb` pulses for one cycle at elapsed cycle 4*(low+1) of each low phase, counting the first low cycle as 0.
- R5: `sample_stb` pulses for one cycle at elapsed cycle 4*(high+1) of each high phase, counting the first high cycle as 0.
- R6: `low_done` pulses on the last cycle of each low phase, and `high_done` pulses on the last cycle of each high phase.
- R7: `div_word` is captured only on the clock edge that enters a low phase. A change at any other time first affects the next full period.
- R8: While `enable` is 0, in the same cycle, `scl` is 1 and every strobe is 0. The generator returns to idle and restarts from a fresh low phase.
- R9: The first low cycle is the cycle after the first rising clock edge that samples `enable` = 1 while the block is idle.
- R10: A divider field of 0 is legal and gives a phase of exactly 8 clocks, with its midpoint strobe at elapsed cycle 4.
- R11: During reset, `scl` is 1 and all strobes are 0, even with `enable` held high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Run the generator; 0 releases SCL high |
| div_word | input | 32 | High divider in [31:16], low divider in [15:0] |
| scl | output | 1 | SCL level (0 = drive low) |
| launch_stb | output | 1 | One-cycle pulse at mid low phase |
| sample_stb | output | 1 | One-cycle pulse at mid high phase |
| low_done | output | 1 | Pulse on last cycle of a low phase |
| high_done | output | 1 | Pulse on last cycle of a high phase |

## Verification
The hardest case to reach from the ports is a divider word that changes while a period is already running. That change must stay invisible until the next edge that enters a low phase, and the high half of the current period must keep its old length. The stimulus rewrites `div_word` a few cycles into the first low phase of a burst. The scoreboard then expects old timings for the whole first period and new timings from the second period on. A separate run drops `enable` in the middle of a long low phase, checks that SCL is released at once, and re-enables the block to confirm a clean restart of the prescaler.

// File: rtl/sclk_pkg.sv
package sclk_pkg;
    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_LOW  = 2'd1,
        ST_HIGH = 2'd2
    } sclk_state_e;
endpackage

// File: rtl/sclk_prescale.sv
module sclk_prescale #(
    parameter int PRE_LOG2 = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clear,
    output logic [PRE_LOG2-1:0] pre,
    output logic                tick
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     pre <= '0;
        else if (clear) pre <= '0;
        else            pre <= pre + 1'b1;
    end

    assign tick = &pre;
endmodule

// File: rtl/sclk_phase_cnt.sv
module sclk_phase_cnt #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [DIV_W-1:0] load_val,
    input  logic             dec,
    output logic [DIV_W-1:0] cnt,
    output logic             zero
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)               cnt <= '0;
        else if (load)            cnt <= load_val;
        else if (dec && cnt != '0) cnt <= cnt - 1'b1;
    end

    assign zero = (cnt == '0);
endmodule

// File: rtl/sclk_mid_hit.sv
module sclk_mid_hit #(
    parameter int DIV_W    = 16,
    parameter int PRE_LOG2 = 3
) (
    input  logic [DIV_W-1:0]    div,
    input  logic [DIV_W-1:0]    cnt,
    input  logic [PRE_LOG2-1:0] pre,
    output logic                hit
);
    // Midpoint of a phase of 2^PRE_LOG2*(div+1) cycles.
    localparam logic [PRE_LOG2-1:0] HALF_V = PRE_LOG2'(1 << (PRE_LOG2 - 1));

    logic [PRE_LOG2-1:0] pre_goal;

    // Odd divider: midpoint falls on a unit boundary; even: half a unit in.
    assign pre_goal = div[0] ? '0 : HALF_V;
    assign hit      = (cnt == (div >> 1)) && (pre == pre_goal);
endmodule

// File: rtl/scl_split_clkgen.sv
module scl_split_clkgen
    import sclk_pkg::*;
#(
    parameter int DIV_W    = 16,
    parameter int PRE_LOG2 = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               enable,
    input  logic [2*DIV_W-1:0] div_word,
    output logic               scl,
    output logic               launch_stb,
    output logic               sample_stb,
    output logic               low_done,
    output logic               high_done
);
    localparam int WORD_W = 2 * DIV_W;

    sclk_state_e         st_q, st_d;
    logic [DIV_W-1:0]    lo_q, hi_q;
    logic [DIV_W-1:0]    fld_lo, fld_hi;
    logic [DIV_W-1:0]    cnt, load_val, cur_div;
    logic [PRE_LOG2-1:0] pre;
    logic                tick, zero, lat, load, run, mid_hit, phase_end;

    assign fld_lo    = div_word[DIV_W-1:0];
    assign fld_hi    = div_word[WORD_W-1:DIV_W];
    assign run       = enable && (st_q != ST_OFF);
    assign phase_end = run && tick && zero;

    // Next-state logic
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_OFF:  if (enable) st_d = ST_LOW;
            ST_LOW:  if (!enable) st_d = ST_OFF;
                     else if (phase_end) st_d = ST_HIGH;
            ST_HIGH: if (!enable) st_d = ST_OFF;
                     else if (phase_end) st_d = ST_LOW;
            default: st_d = ST_OFF;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_OFF;
        else        st_q <= st_d;
    end

    // Divider capture only when a low phase begins
    assign lat = (st_d == ST_LOW) && (st_q != ST_LOW);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lo_q <= '0;
            hi_q <= '0;
        end else if (lat) begin
            lo_q <= fld_lo;
            hi_q <= fld_hi;
        end
    end

    assign load     = lat || ((st_d == ST_HIGH) && (st_q != ST_HIGH));
    assign load_val = lat ? fld_lo : hi_q;
    assign cur_div  = (st_q == ST_HIGH) ? hi_q : lo_q;

    sclk_prescale #(.PRE_LOG2(PRE_LOG2)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (!run),
        .pre   (pre),
        .tick  (tick)
    );

    sclk_phase_cnt #(.DIV_W(DIV_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .load_val (load_val),
        .dec      (run && tick),
        .cnt      (cnt),
        .zero     (zero)
    );

    sclk_mid_hit #(.DIV_W(DIV_W), .PRE_LOG2(PRE_LOG2)) u_mid (
        .div (cur_div),
        .cnt (cnt),
        .pre (pre),
        .hit (mid_hit)
    );

    // Output decode
    always_comb begin
        scl        = !(run && (st_q == ST_LOW));
        launch_stb = run && (st_q == ST_LOW)  && mid_hit;
        sample_stb = run && (st_q == ST_HIGH) && mid_hit;
        low_done   = run && (st_q == ST_LOW)  && tick && zero;
        high_done  = run && (st_q == ST_HIGH) && tick && zero;
    end
endmodule

// File: rtl/sclk_checker.sv
module sclk_checker
    import sclk_pkg::*;
#(
    parameter int DIV_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             enable,
    input logic             scl,
    input logic             launch_stb,
    input logic             sample_stb,
    input logic             low_done,
    input logic             high_done,
    input sclk_state_e      st_q,
    input logic [DIV_W-1:0] lo_q,
    input logic [DIV_W-1:0] hi_q,
    input logic             lat
);
    p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |-> (scl && !launch_stb && !sample_stb && !low_done && !high_done));

    p_single_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({launch_stb, sample_stb, low_done, high_done}));

    p_launch_in_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
        launch_stb |-> !scl);

    p_sample_in_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
        sample_stb |-> scl);

    p_rise_after_low_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
        low_done |=> (scl || !enable));

    p_fall_after_high_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
        high_done |=> (!scl || !enable));

    p_fall_source_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(scl) |-> ($past(high_done) || $past(st_q == ST_OFF)));

    p_capture_only_on_entry_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(lo_q) || !$stable(hi_q)) |-> $past(lat));
endmodule

bind scl_split_clkgen sclk_checker #(.DIV_W(DIV_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable     (enable),
    .scl        (scl),
    .launch_stb (launch_stb),
    .sample_stb (sample_stb),
    .low_done   (low_done),
    .high_done  (high_done),
    .st_q       (st_q),
    .lo_q       (lo_q),
    .hi_q       (hi_q),
    .lat        (lat)
);

// File: tb/sim_scl_split_clkgen.sv
module sim_scl_split_clkgen;
    localparam int K_FALL = 1, K_LAUNCH = 2, K_LDONE = 3, K_RISE = 4,
                   K_SAMPLE = 5, K_HDONE = 6, K_MULTI = 7;

    typedef struct {
        int    kind;
        int    at;
        string tag;
    } ev_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0;
    logic [31:0] div_word = '0;
    logic        scl, launch_stb, sample_stb, low_done, high_done;

    int  cyc = 0;
    int  n_vec = 0;
    int  n_bad = 0;
    bit  mon_on = 1'b0;
    bit  prev_scl = 1'b1;
    bit  finished = 1'b0;
    ev_t q[$];

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    scl_split_clkgen u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (enable),
        .div_word   (div_word),
        .scl        (scl),
        .launch_stb (launch_stb),
        .sample_stb (sample_stb),
        .low_done   (low_done),
        .high_done  (high_done)
    );

    // Monitor: turn port activity into events and compare with the queue
    always @(negedge clk) begin
        int  hits;
        int  kind;
        ev_t e;
        if (rst_n && mon_on) begin
            hits = int'(launch_stb) + int'(sample_stb) + int'(low_done)
                 + int'(high_done) + int'(scl != prev_scl);
            kind = 0;
            if (hits > 1)                  kind = K_MULTI;
            else if (scl != prev_scl)      kind = scl ? K_RISE : K_FALL;
            else if (launch_stb)           kind = K_LAUNCH;
            else if (sample_stb)           kind = K_SAMPLE;
            else if (low_done)             kind = K_LDONE;
            else if (high_done)            kind = K_HDONE;
            if (kind != 0) begin
                n_vec++;
                if (q.size() == 0) begin
                    n_bad++;
                    $display("FAIL R6: unexpected event kind %0d at cycle %0d, expected none", kind, cyc);
                end else begin
                    e = q.pop_front();
                    if (e.kind != kind || e.at != cyc) begin
                        n_bad++;
                        $display("FAIL %s: event kind %0d at cycle %0d, expected kind %0d at cycle %0d",
                                 e.tag, kind, cyc, e.kind, e.at);
                    end
                end
            end
        end
        prev_scl = scl;
    end

    function automatic void push(int kind, int at, string tag);
        ev_t e;
        e.kind = kind;
        e.at   = at;
        e.tag  = tag;
        q.push_back(e);
    endfunction

    // Driver: run k periods; optionally rewrite the divider at offset chg_at
    task automatic run_burst(input logic [15:0] lo, input logic [15:0] hi,
                             input logic [15:0] lo2, input logic [15:0] hi2,
                             input int k, input int chg_at, input string ovr);
        int c, c0, end_c, llo, lhi;
        logic [15:0] ul, uh;
        string t;
        @(negedge clk); #1;
        div_word = {hi, lo};
        enable   = 1'b1;
        c0 = cyc + 1;
        c  = c0;
        for (int p = 0; p < k; p++) begin
            ul = (p == 0 || chg_at < 0) ? lo : lo2;
            uh = (p == 0 || chg_at < 0) ? hi : hi2;
            llo = 8 * (int'(ul) + 1);
            lhi = 8 * (int'(uh) + 1);
            t = (ovr != "") ? ovr : "";
            if (p > 0 && chg_at >= 0) t = "R7";
            push(K_FALL,   c,                 (t != "") ? t : ((p == 0) ? "R9" : "R3"));
            push(K_LAUNCH, c + llo / 2,       (t != "") ? t : "R4");
            push(K_LDONE,  c + llo - 1,       (t != "") ? t : "R6");
            push(K_RISE,   c + llo,           (t != "") ? t : "R2");
            push(K_SAMPLE, c + llo + lhi / 2, (t != "") ? t : "R5");
            push(K_HDONE,  c + llo + lhi - 1, (t != "") ? t : "R6");
            c = c + llo + lhi;
        end
        end_c = c - 1;
        while (cyc != end_c) begin
            @(negedge clk); #1;
            if (chg_at >= 0 && cyc == c0 + chg_at) div_word = {hi2, lo2};
        end
        enable = 1'b0;
        repeat (4) @(negedge clk);
        #1;
        n_vec++;
        if (q.size() != 0) begin
            n_bad++;
            $display("FAIL R2: %0d expected events never seen, expected 0", q.size());
            q.delete();
        end
    endtask

    initial begin
        bit ok;
        enable = 1'b1;
        repeat (3) @(negedge clk);
        n_vec++;
        if (!(scl && !launch_stb && !sample_stb && !low_done && !high_done)) begin
            n_bad++;
            $display("FAIL R11: outputs %b%b%b%b%b in reset, expected 10000",
                     scl, launch_stb, sample_stb, low_done, high_done);
        end
        #1 enable = 1'b0;
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        prev_scl = scl;
        mon_on = 1'b1;

        run_burst(16'd0,  16'd0, 16'd0, 16'd0, 3, -1, "R10");
        run_burst(16'd3,  16'd1, 16'd0, 16'd0, 2, -1, "");
        run_burst(16'd2,  16'd5, 16'd0, 16'd0, 2, -1, "R1");
        run_burst(16'd4,  16'd1, 16'd1, 16'd6, 3,  3, "");
        run_burst(16'd40, 16'd7, 16'd0, 16'd0, 1, -1, "");

        // Abort in mid low phase: SCL released at once, no strobes afterwards (R8)
        mon_on = 1'b0;
        @(negedge clk); #1;
        div_word = {16'd5, 16'd5};
        enable = 1'b1;
        repeat (10) @(negedge clk);
        #1 enable = 1'b0;
        #1;
        n_vec++;
        if (!(scl && !launch_stb && !sample_stb && !low_done && !high_done)) begin
            n_bad++;
            $display("FAIL R8: outputs %b%b%b%b%b after enable drop, expected 10000",
                     scl, launch_stb, sample_stb, low_done, high_done);
        end
        ok = 1'b1;
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            if (!(scl && !launch_stb && !sample_stb && !low_done && !high_done)) ok = 1'b0;
        end
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL R8: activity while disabled, expected scl=1 and no strobes");
        end
        prev_scl = scl;
        mon_on = 1'b1;
        // Restart after abort must begin with a full fresh low phase (R8, R9)
        run_burst(16'd5, 16'd2, 16'd0, 16'd0, 2, -1, "R8");

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        finished = 1'b1;
        $finish;
    end

    initial begin
        #(20 * 100000);
        if (!finished) begin
            n_bad++;
            $display("FAIL R2: watchdog expired, expected run to complete");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule